// File: doc/BRIEF.md
# Power Domain Sequencer

This block powers a gated logic domain up and down in hardware. A pulse on the power-on request starts a fixed sequence that drives four kinds of control: the domain power switch with its two clock enables, a set of memory power-down controls, a vector of active-low module resets, and the isolation clamp. Power-down runs the mirror of that order. The block waits a set number of cycles between steps. The wait counts come from the clock frequency, so the settle times stay the same in microseconds when the clock changes.

The memory controls come in two groups. The first is `NUM_MEM_FIELDS` two-bit fields, where field i sits at bits [2i+1:2i]. The second is `NUM_AUX_BITS` single-bit controls. The block changes one field or one bit per step and waits a short settle time after each change. This keeps the inrush current low. While a sequence runs, `busy` is high. A one-cycle `done` pulse marks the end of the sequence.

Top module: `pdom_sequencer`

## Requirements
- R1: After reset the domain is off: `dom_sw_en`=0, `clk_en`=2'b00, `iso_en`=1, `rst_out_n` all 0, every memory field 2'b11, every single-bit memory control 1, and `busy`=0 and `done`=0.
- R2: Power-up order:
  - `dom_sw_en`=1 and `clk_en`=2'b11 (bit 0 is the bus clock, bit 1 the core clock), then a long settle;
  - the memory steps, then a further long settle;
  - the reset steps;
  - `iso_en`=0, one cycle after the resets are released.
- R3: Memory fields are stepped one per step in ascending index order, each followed by a short settle. Power-up writes 2'b00 and power-down writes 2'b11.
- R4: The single-bit memory controls are stepped after all two-bit fields, one per step in ascending order, each followed by a short settle. A 0 powers a memory up and a 1 powers it down.
- R5: Resets are active low. On power-up all `rst_out_n` bits are cleared. One short settle later they are all set.
- R6: Power-down order:
  - `iso_en`=1, then a long settle;
  - the memory steps with their short settles, then a further long settle;
  - `dom_sw_en`=0;
  - `clk_en`=2'b00 one cycle later.
- R7: The long settle is ceil(`CLK_FREQ_HZ`·`SETTLE_US`/10^6) cycles and the short settle is ceil(`CLK_FREQ_HZ`·`STEP_US`/10^6) cycles. Each is at least 1. The spacing between consecutive actions equals the sum of the settles between them.
- R8: Timing of the handshake:
  - `busy` rises on the clock edge that accepts a request.
  - The first output change comes one cycle after that.
  - On the edge of the final output change, `busy` falls and `done` is high for exactly one cycle.
- R9: These requests are ignored and cause no output change:
  - any request while `busy` is high;
  - `pwr_on_req` while the domain is on;
  - `pwr_off_req` while the domain is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_req | input | 1 | Request to power the domain up |
| pwr_off_req | input | 1 | Request to power the domain down |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence completes |
| dom_sw_en | output | 1 | Domain power switch closed when 1 |
| clk_en | output | 2 | Clock enables: bit 0 bus clock, bit 1 core clock |
| iso_en | output | 1 | Isolation clamp active when 1 |
| rst_out_n | output | NUM_RESETS | Active-low module resets |
| mem_pd_fld | output | 2*NUM_MEM_FIELDS | Two-bit memory power-down fields, 2'b11 = down |
| mem_pd_bit | output | NUM_AUX_BITS | Single-bit memory power-down controls, 1 = down |

## Verification
The bench builds the block with three memory fields, four resets and a 1 MHz `CLK_FREQ_HZ`. This makes the long settle 20 cycles and the short settle 5 cycles, so one full sequence takes about a hundred cycles. Several complete power-up and power-down passes then fit in the run. Every output change is timed exactly against the settle arithmetic. Requests can be injected part-way through a sequence. The second power-up starts from resets that are already released, so the reset-assert step is visible on the outputs.

// File: rtl/pdom_seq_pkg.sv
package pdom_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF, ST_ON,
    UP_SW, UP_MEM, UP_AUX, UP_GAP, UP_RST, UP_REL, UP_ISO,
    DN_ISO, DN_MEM, DN_AUX, DN_GAP, DN_SW, DN_CLK
  } seq_state_e;

  // Settle time in cycles, rounded up, never below one cycle.
  function automatic int unsigned us_to_cycles(longint unsigned freq_hz, int unsigned usec);
    longint unsigned c;
    c = (freq_hz * longint'(usec) + 64'd999_999) / 64'd1_000_000;
    if (c == 64'd0) c = 64'd1;
    return int'(c[31:0]);
  endfunction

  // Width that can hold values 0 .. n-1, at least one bit.
  function automatic int unsigned idx_width(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pdom_step_timer.sv
module pdom_step_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          idle
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign idle = (cnt == '0);

  // R7: a nonzero reload keeps the next step waiting
  a_r7_reload_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !idle);

  // R7: the last count cycle releases the next step
  a_r7_countdown_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt == CW'(1)) |=> idle);

endmodule

// File: rtl/pdom_mem_bank.sv
module pdom_mem_bank #(
  parameter int unsigned NF  = 8,
  parameter int unsigned NB  = 8,
  parameter int unsigned FIW = 3,
  parameter int unsigned BIW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fld_we,
  input  logic [FIW-1:0]  fld_idx,
  input  logic            bit_we,
  input  logic [BIW-1:0]  bit_idx,
  input  logic            pd_val,
  output logic [2*NF-1:0] fld_pd,
  output logic [NB-1:0]   bit_pd
);

  for (genvar i = 0; i < NF; i++) begin : g_fld
    logic [1:0] f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               f_q <= 2'b11;
      else if (fld_we && fld_idx == FIW'(i))    f_q <= {2{pd_val}};
    end
    assign fld_pd[2*i +: 2] = f_q;
  end

  for (genvar j = 0; j < NB; j++) begin : g_bit
    logic b_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               b_q <= 1'b1;
      else if (bit_we && bit_idx == BIW'(j))    b_q <= pd_val;
    end
    assign bit_pd[j] = b_q;
  end

  // R3: a step touches either the field group or the single-bit group, never both
  a_r3_one_group: assert property (@(posedge clk) disable iff (!rst_n)
    !(fld_we && bit_we));

endmodule

// File: rtl/pdom_sequencer.sv
module pdom_sequencer #(
  parameter longint unsigned CLK_FREQ_HZ    = 100_000_000,
  parameter int unsigned     SETTLE_US      = 20,
  parameter int unsigned     STEP_US        = 5,
  parameter int unsigned     NUM_MEM_FIELDS = 8,
  parameter int unsigned     NUM_AUX_BITS   = 8,
  parameter int unsigned     NUM_RESETS     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pwr_on_req,
  input  logic                        pwr_off_req,
  output logic                        busy,
  output logic                        done,
  output logic                        dom_sw_en,
  output logic [1:0]                  clk_en,
  output logic                        iso_en,
  output logic [NUM_RESETS-1:0]       rst_out_n,
  output logic [2*NUM_MEM_FIELDS-1:0] mem_pd_fld,
  output logic [NUM_AUX_BITS-1:0]     mem_pd_bit
);
  import pdom_seq_pkg::*;

  localparam int unsigned LONG_CYC  = us_to_cycles(CLK_FREQ_HZ, SETTLE_US);
  localparam int unsigned SHORT_CYC = us_to_cycles(CLK_FREQ_HZ, STEP_US);
  localparam int unsigned MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int unsigned CW        = idx_width(MAX_CYC);
  localparam int unsigned FIW       = idx_width(NUM_MEM_FIELDS);
  localparam int unsigned BIW       = idx_width(NUM_AUX_BITS);
  localparam int unsigned IDX_N     = (NUM_MEM_FIELDS > NUM_AUX_BITS) ? NUM_MEM_FIELDS : NUM_AUX_BITS;
  localparam int unsigned IW        = idx_width(IDX_N);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYC - 1);
  localparam logic [IW-1:0] FLD_LAST = IW'(NUM_MEM_FIELDS - 1);
  localparam logic [IW-1:0] BIT_LAST = IW'(NUM_AUX_BITS - 1);

  seq_state_e      state;
  logic [IW-1:0]   idx;
  logic            t_idle;
  logic            step_go;
  logic [CW-1:0]   t_val;
  logic            fld_we, bit_we, pd_val;
  logic            idx_last;

  // Named step events
  always_comb begin
    step_go  = t_idle && (state != ST_OFF) && (state != ST_ON);
    fld_we   = step_go && (state == UP_MEM || state == DN_MEM);
    bit_we   = step_go && (state == UP_AUX || state == DN_AUX);
    pd_val   = (state == DN_MEM) || (state == DN_AUX);
    idx_last = (state == UP_MEM || state == DN_MEM) ? (idx == FLD_LAST) : (idx == BIT_LAST);
    unique case (state)
      UP_SW, UP_GAP, DN_ISO, DN_GAP:          t_val = LONG_LD;
      UP_MEM, UP_AUX, UP_RST, DN_MEM, DN_AUX: t_val = SHORT_LD;
      default:                                t_val = '0;
    endcase
  end

  pdom_step_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(step_go), .load_val(t_val), .idle(t_idle)
  );

  pdom_mem_bank #(.NF(NUM_MEM_FIELDS), .NB(NUM_AUX_BITS), .FIW(FIW), .BIW(BIW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .fld_we(fld_we), .fld_idx(idx[FIW-1:0]),
    .bit_we(bit_we), .bit_idx(idx[BIW-1:0]),
    .pd_val(pd_val), .fld_pd(mem_pd_fld), .bit_pd(mem_pd_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OFF;
      idx       <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      dom_sw_en <= 1'b0;
      clk_en    <= 2'b00;
      iso_en    <= 1'b1;
      rst_out_n <= '0;
    end else begin
      done <= 1'b0;
      if (state == ST_OFF) begin
        if (pwr_on_req) begin state <= UP_SW; busy <= 1'b1; end
      end else if (state == ST_ON) begin
        if (pwr_off_req) begin state <= DN_ISO; busy <= 1'b1; end
      end else if (step_go) begin
        unique case (state)
          UP_SW: begin
            dom_sw_en <= 1'b1;
            clk_en    <= 2'b11;
            idx       <= '0;
            state     <= UP_MEM;
          end
          UP_MEM, DN_MEM: begin
            if (idx_last) begin
              idx   <= '0;
              state <= (state == UP_MEM) ? UP_AUX : DN_AUX;
            end else idx <= idx + 1'b1;
          end
          UP_AUX, DN_AUX: begin
            if (idx_last) begin
              idx   <= '0;
              state <= (state == UP_AUX) ? UP_GAP : DN_GAP;
            end else idx <= idx + 1'b1;
          end
          UP_GAP: state <= UP_RST;
          UP_RST: begin rst_out_n <= '0; state <= UP_REL; end
          UP_REL: begin rst_out_n <= '1; state <= UP_ISO; end
          UP_ISO: begin
            iso_en <= 1'b0;
            busy   <= 1'b0;
            done   <= 1'b1;
            state  <= ST_ON;
          end
          DN_ISO: begin iso_en <= 1'b1; idx <= '0; state <= DN_MEM; end
          DN_GAP: state <= DN_SW;
          DN_SW:  begin dom_sw_en <= 1'b0; state <= DN_CLK; end
          DN_CLK: begin
            clk_en <= 2'b00;
            busy   <= 1'b0;
            done   <= 1'b1;
            state  <= ST_OFF;
          end
          default: state <= ST_OFF;
        endcase
      end
    end
  end

  // R6: a memory control only moves toward power-down while clamped
  a_r6_iso_before_mem_down: assert property (@(posedge clk) disable iff (!rst_n)
    (((mem_pd_fld & ~$past(mem_pd_fld)) != '0) || ((mem_pd_bit & ~$past(mem_pd_bit)) != '0))
      |-> iso_en);

  // R2: a memory control only moves toward power-up with the switch closed
  a_r2_mem_up_needs_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (((~mem_pd_fld & $past(mem_pd_fld)) != '0) || ((~mem_pd_bit & $past(mem_pd_bit)) != '0))
      |-> dom_sw_en);

  // R5: the clamp drops only once every reset is released
  a_r5_iso_off_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> (&rst_out_n));

  // R6: the switch opens only with every memory powered down
  a_r6_switch_open_mem_down: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dom_sw_en) |-> ((&mem_pd_fld) && (&mem_pd_bit)));

  // R3: at most one field (two bits) changes in a cycle
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({mem_pd_fld ^ $past(mem_pd_fld), mem_pd_bit ^ $past(mem_pd_bit)}) <= 2));

  // R8: done never overlaps busy and lasts one cycle
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/pdom_sequencer_bench.sv
module pdom_sequencer_bench;
  localparam longint unsigned FREQ = 1_000_000;
  localparam int NF = 3;
  localparam int NB = 8;
  localparam int NR = 4;
  localparam int BW = 1 + 2 + 1 + NR + 2*NF + NB;

  // Settle lengths restated from R7: microseconds times cycles per microsecond.
  function automatic int cycles_of(int usec);
    int c;
    c = usec * int'(FREQ / 1_000_000);
    return (c < 1) ? 1 : c;
  endfunction
  localparam int LONG  = 20;
  localparam int SHORT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_on_req = 1'b0;
  logic pwr_off_req = 1'b0;
  logic busy, done, dom_sw_en, iso_en;
  logic [1:0] clk_en;
  logic [NR-1:0] rst_out_n;
  logic [2*NF-1:0] mem_pd_fld;
  logic [NB-1:0] mem_pd_bit;

  always #5 clk = ~clk;

  pdom_sequencer #(
    .CLK_FREQ_HZ(FREQ), .SETTLE_US(20), .STEP_US(5),
    .NUM_MEM_FIELDS(NF), .NUM_AUX_BITS(NB), .NUM_RESETS(NR)
  ) u_pdom_sequencer (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
    .busy(busy), .done(done), .dom_sw_en(dom_sw_en), .clk_en(clk_en), .iso_en(iso_en),
    .rst_out_n(rst_out_n), .mem_pd_fld(mem_pd_fld), .mem_pd_bit(mem_pd_bit)
  );

  wire [BW-1:0] obs = {dom_sw_en, clk_en, iso_en, rst_out_n, mem_pd_fld, mem_pd_bit};

  typedef struct {
    bit          first;
    bit          last;
    int          delta;
    logic [BW-1:0] val;
    string       tag;
  } exp_t;
  exp_t q[$];

  int drv_checks = 0, drv_fail = 0, mon_checks = 0, mon_fail = 0, wd_fail = 0;
  int cyc = 0;
  int req_edge = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Model of the outputs
  logic m_sw, m_iso;
  logic [1:0] m_clk;
  logic [NR-1:0] m_rst;
  logic [2*NF-1:0] m_fld;
  logic [NB-1:0] m_bit;
  logic [BW-1:0] m_cur;
  int acc;
  bit first_pending;

  function automatic logic [BW-1:0] pack_model();
    return {m_sw, m_clk, m_iso, m_rst, m_fld, m_bit};
  endfunction

  task automatic emit(string tag, bit last);
    exp_t it;
    logic [BW-1:0] v;
    v = pack_model();
    if (v !== m_cur) begin
      it.first = first_pending; it.last = last; it.delta = acc;
      it.val = v; it.tag = tag;
      q.push_back(it);
      first_pending = 1'b0; acc = 0; m_cur = v;
    end
  endtask

  task automatic build_up();
    first_pending = 1'b1; acc = 1;
    m_sw = 1'b1; m_clk = 2'b11; emit("R2", 1'b0); acc += cycles_of(LONG);
    for (int i = 0; i < NF; i++) begin m_fld[2*i +: 2] = 2'b00; emit("R3", 1'b0); acc += cycles_of(SHORT); end
    for (int i = 0; i < NB; i++) begin m_bit[i] = 1'b0; emit("R4", 1'b0); acc += cycles_of(SHORT); end
    acc += cycles_of(LONG);
    m_rst = '0; emit("R5", 1'b0); acc += cycles_of(SHORT);
    m_rst = '1; emit("R5", 1'b0); acc += 1;
    m_iso = 1'b0; emit("R2", 1'b1);
  endtask

  task automatic build_down();
    first_pending = 1'b1; acc = 1;
    m_iso = 1'b1; emit("R6", 1'b0); acc += cycles_of(LONG);
    for (int i = 0; i < NF; i++) begin m_fld[2*i +: 2] = 2'b11; emit("R3", 1'b0); acc += cycles_of(SHORT); end
    for (int i = 0; i < NB; i++) begin m_bit[i] = 1'b1; emit("R4", 1'b0); acc += cycles_of(SHORT); end
    acc += cycles_of(LONG);
    m_sw = 1'b0; emit("R6", 1'b0); acc += 1;
    m_clk = 2'b00; emit("R6", 1'b1);
  endtask

  // Monitor: pops the expected trace as the outputs move
  logic [BW-1:0] prev;
  int last_cyc = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev = obs; last_cyc = cyc;
    end else if (obs !== prev) begin
      if (q.size() == 0) begin
        mon_checks++; mon_fail++;
        $display("FAIL R9 unexpected output change: actual %h expected %h", obs, prev);
      end else begin
        exp_t it;
        int d;
        it = q.pop_front();
        d = it.first ? (cyc - req_edge) : (cyc - last_cyc);
        mon_checks++;
        if (obs !== it.val) begin
          mon_fail++;
          $display("FAIL %s outputs: actual %h expected %h", it.tag, obs, it.val);
        end
        mon_checks++;
        if (d != it.delta) begin
          mon_fail++;
          $display("FAIL %s R7 spacing: actual %0d expected %0d", it.tag, d, it.delta);
        end
        mon_checks++;
        if (it.last ? !(done === 1'b1 && busy === 1'b0) : !(busy === 1'b1 && done === 1'b0)) begin
          mon_fail++;
          $display("FAIL R8 handshake busy/done: actual %b%b expected %b%b",
                   busy, done, ~it.last, it.last);
        end
      end
      prev = obs; last_cyc = cyc;
    end
  end

  task automatic drv_check(bit ok, string what, logic [BW-1:0] act, logic [BW-1:0] exp);
    drv_checks++;
    if (!ok) begin
      drv_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic request(bit on, bit off);
    @(negedge clk);
    pwr_on_req = on; pwr_off_req = off;
    req_edge = cyc + 1;
    @(negedge clk);
    pwr_on_req = 1'b0; pwr_off_req = 1'b0;
  endtask

  task automatic pulse_ignored(bit on, bit off);
    @(negedge clk);
    pwr_on_req = on; pwr_off_req = off;
    @(negedge clk);
    pwr_on_req = 1'b0; pwr_off_req = 1'b0;
  endtask

  task automatic wait_trace();
    for (int i = 0; i < 2000 && q.size() != 0; i++) @(negedge clk);
    drv_check(q.size() == 0, "R2 R6 trace incomplete", BW'(q.size()), '0);
    @(negedge clk);
    drv_check(done === 1'b0 && busy === 1'b0, "R8 done lasts one cycle", BW'({busy, done}), '0);
  endtask

  task automatic report();
    int total, failed;
    total  = drv_checks + mon_checks + wd_fail;
    failed = drv_fail + mon_fail + wd_fail;
    $display("%0d/%0d checks passed", total - failed, total);
  endtask

  initial begin
    m_sw = 1'b0; m_clk = 2'b00; m_iso = 1'b1; m_rst = '0; m_fld = '1; m_bit = '1;
    m_cur = pack_model();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    drv_check(obs === m_cur, "R1 reset outputs", obs, m_cur);
    drv_check(busy === 1'b0 && done === 1'b0, "R1 reset handshake", BW'({busy, done}), '0);

    // Off request while off: ignored
    pulse_ignored(1'b0, 1'b1);
    repeat (5) @(negedge clk);
    drv_check(busy === 1'b0 && obs === m_cur, "R9 off request while off", obs, m_cur);

    // First power-up, with stray requests mid-sequence
    build_up();
    request(1'b1, 1'b0);
    drv_check(busy === 1'b1, "R8 busy after accept", BW'(busy), BW'(1));
    repeat (30) @(negedge clk);
    pulse_ignored(1'b0, 1'b1);
    repeat (10) @(negedge clk);
    pulse_ignored(1'b1, 1'b0);
    wait_trace();

    // On request while on: ignored
    pulse_ignored(1'b1, 1'b0);
    repeat (5) @(negedge clk);
    drv_check(busy === 1'b0 && obs === m_cur, "R9 on request while on", obs, m_cur);

    // Power-down, with a stray on request
    build_down();
    request(1'b0, 1'b1);
    repeat (40) @(negedge clk);
    pulse_ignored(1'b1, 1'b0);
    wait_trace();

    // Second power-up from released resets, both requests together
    build_up();
    request(1'b1, 1'b1);
    wait_trace();

    // Second power-down with both requests together
    build_down();
    request(1'b1, 1'b1);
    wait_trace();
    drv_check(obs === m_cur, "R6 final off outputs", obs, m_cur);

    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      wd_fail = 1;
      $display("FAIL watchdog expired: actual running expected finished");
      report();
      $finish;
    end
  end

endmodule